// File: doc/BRIEF.md
# Latency-Perturbing Bus Synchronizer Model

This block stands in for a multi-bit two-stage synchronizer in the receiving clock domain. It differs from a plain synchronizer in one way. Whenever a bit's input differs from the value held in its first stage, a transition is being captured, and the block can deliver that transition to the output one cycle earlier or one cycle later than a plain two-stage synchronizer would. Logic downstream of it then sees the early and late arrivals that a metastable first stage can produce in silicon. Any design whose correctness hinges on one exact crossing latency is exposed as a result.

Every bit runs in its own lane, and each lane has a small state machine with two states:
- `LANE_NOMINAL`: the lane forwards normally, or applies a perturbation.
- `LANE_HELD`: the lane has just stalled its first stage and must forward normally for exactly one cycle.

The transitions are:
- *late pick*: `LANE_NOMINAL` to `LANE_HELD`.
- *release*: `LANE_HELD` to `LANE_NOMINAL`, taken unconditionally.

Every other case keeps the lane in `LANE_NOMINAL`. A bank of 16-bit Galois LFSRs supplies two random bits per lane per cycle. The bank is loaded from `seed` during reset, so a given seed repeats the same choices. A per-bit enable turns the injection off, and a disabled bit becomes an exact two-stage synchronizer. Per-bit event flags report each perturbation, which lets a bench collect coverage.

Top module: `msync_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages and flags clear. `sync_out`, `delay_evt` and `bleed_evt` then read all zeros.
- R2: A bit whose `inj_en` is 0 behaves as an ideal two-stage synchronizer.
  - Its output equals the input sampled two edges earlier.
  - Its event flags stay 0.
- R3: The lane's two random bits form a pick code. Code 00 or 01 means no perturbation, and the transition reaches `sync_out` on the second rising edge after it is first sampled.
- R4: Pick code 10 is the late pick. The first stage keeps its old value for that edge, and the transition reaches `sync_out` on the third edge. `delay_evt` for that bit is 1 during the cycle after the first edge.
- R5: Pick code 11 is the early pick. The raw input goes into the second stage on the first edge, so `sync_out` changes after one edge. `bleed_evt` is 1 during the cycle after that edge.
- R6: The edge after a late pick always forwards normally. No further perturbation can be applied there, so a transition's latency lies between 1 and 3 edges.
- R7: A perturbation is applied only on an edge where the bit's input differs from its first stage. A stable input never raises an event flag and never moves the output.
- R8: Each bit draws its own pick code. Bits that toggle on the same edge can therefore receive different latencies.
- R9: Once an input has been stable for three edges, `sync_out` equals the input.
- R10: For a given bit, `delay_evt` and `bleed_evt` are never 1 in the same cycle. Each flag lasts one cycle per perturbation.
- R11: The random sequence depends only on the `seed` value present during reset. Resetting with the same seed and applying the same stimulus reproduces the same event flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination-domain clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; also loads the seed |
| async_in | input | W | Bus arriving from another clock domain |
| inj_en | input | W | Per-bit permission to perturb latency |
| seed | input | 16 | Seed for the random bank, sampled while in reset |
| sync_out | output | W | Synchronized bus |
| delay_evt | output | W | Per-bit one-cycle flag: a late pick was applied |
| bleed_evt | output | W | Per-bit one-cycle flag: an early pick was applied |

## Verification
The bench drives four kinds of stimulus:
- Pseudo-random sparse toggles with injection off. These must show the exact two-edge latency.
- The same toggles with injection on. Here every latency of 1, 2 and 3 must appear, and each must agree with the event flag that announced it.
- Whole-bus toggles. These separate per-bit choices from one shared choice, because a shared choice would never give bits different latencies.
- A half-enabled mask, followed by a long stable stretch. These check that perturbations stay confined to enabled bits and to cycles with a transition pending.

A second reset with the same seed replays the first injected run, and the bench compares the two event histories.

// File: rtl/msync_pkg.sv
package msync_pkg;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] SEED_MIX  = 16'h9E37;

    typedef enum logic {
        LANE_NOMINAL = 1'b0,
        LANE_HELD    = 1'b1
    } lane_state_e;

    typedef enum logic [1:0] {
        PICK_NOM_A = 2'b00,
        PICK_NOM_B = 2'b01,
        PICK_LATE  = 2'b10,
        PICK_EARLY = 2'b11
    } pick_e;

endpackage

// File: rtl/msync_lfsr.sv
module msync_lfsr
    import msync_pkg::*;
#(
    parameter int INDEX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] mixed;
    logic [LFSR_W-1:0] load_val;
    logic [LFSR_W-1:0] next_val;

    always_comb begin
        mixed    = seed ^ (SEED_MIX * LFSR_W'(INDEX + 1));
        load_val = (mixed == '0) ? LFSR_W'(1) : mixed;
        next_val = (state >> 1) ^ (state[0] ? LFSR_TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= load_val;
        end else begin
            state <= next_val;
        end
    end

endmodule

// File: rtl/msync_lane.sv
module msync_lane
    import msync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic       inj,
    input  logic [1:0] pick,
    output logic       dout,
    output logic       late_evt,
    output logic       early_evt
);

    lane_state_e state_q, state_d;
    logic        stage1_q, stage1_d;
    logic        stage2_q, stage2_d;
    logic        late_d, early_d;
    logic        pending;
    pick_e       choice;

    assign pending = (din != stage1_q);
    assign choice  = pick_e'(pick);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LANE_NOMINAL;
            stage1_q  <= 1'b0;
            stage2_q  <= 1'b0;
            late_evt  <= 1'b0;
            early_evt <= 1'b0;
        end else begin
            state_q   <= state_d;
            stage1_q  <= stage1_d;
            stage2_q  <= stage2_d;
            late_evt  <= late_d;
            early_evt <= early_d;
        end
    end

    // Next state and stage values
    always_comb begin
        state_d  = state_q;
        stage1_d = din;
        stage2_d = stage1_q;
        late_d   = 1'b0;
        early_d  = 1'b0;
        unique case (state_q)
            LANE_NOMINAL: begin
                if (inj && pending && (choice == PICK_LATE)) begin
                    stage1_d = stage1_q;
                    late_d   = 1'b1;
                    state_d  = LANE_HELD;
                end else if (inj && pending && (choice == PICK_EARLY)) begin
                    stage2_d = din;
                    early_d  = 1'b1;
                end
            end
            LANE_HELD: begin
                state_d = LANE_NOMINAL;
            end
            default: begin
                state_d = LANE_NOMINAL;
            end
        endcase
    end

    assign dout = stage2_q;

endmodule

// File: rtl/msync_top.sv
module msync_top
    import msync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      async_in,
    input  logic [W-1:0]      inj_en,
    input  logic [LFSR_W-1:0] seed,
    output logic [W-1:0]      sync_out,
    output logic [W-1:0]      delay_evt,
    output logic [W-1:0]      bleed_evt
);

    localparam int RND_BITS = 2 * W;
    localparam int N_GEN    = (RND_BITS + LFSR_W - 1) / LFSR_W;

    logic [N_GEN*LFSR_W-1:0] rnd_pool;

    for (genvar g = 0; g < N_GEN; g++) begin : g_rng
        msync_lfsr #(.INDEX(g)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .seed  (seed),
            .state (rnd_pool[g*LFSR_W +: LFSR_W])
        );
    end

    for (genvar i = 0; i < W; i++) begin : g_lane
        msync_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .din       (async_in[i]),
            .inj       (inj_en[i]),
            .pick      (rnd_pool[2*i +: 2]),
            .dout      (sync_out[i]),
            .late_evt  (delay_evt[i]),
            .early_evt (bleed_evt[i])
        );
    end

endmodule

// File: rtl/msync_chk.sv
module msync_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] async_in,
    input logic [W-1:0] inj_en,
    input logic [W-1:0] sync_out,
    input logic [W-1:0] delay_evt,
    input logic [W-1:0] bleed_evt
);

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 2'd0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    a_r10_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_evt & bleed_evt) == '0);

    a_r2_evt_needs_inj: assert property (@(posedge clk) disable iff (!rst_n)
        ((delay_evt | bleed_evt) & ~$past(inj_en)) == '0);

    a_r5_early_value: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_out ^ $past(async_in)) & bleed_evt) == '0);

    a_r6_no_double_late: assert property (@(posedge clk) disable iff (!rst_n)
        (|delay_evt) |=> (((delay_evt | bleed_evt) & $past(delay_evt)) == '0));

    a_r2_plain_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |->
        (((sync_out ^ $past(async_in, 2)) & ~$past(inj_en) & ~$past(inj_en, 2)) == '0));

endmodule

bind msync_top msync_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (async_in),
    .inj_en    (inj_en),
    .sync_out  (sync_out),
    .delay_evt (delay_evt),
    .bleed_evt (bleed_evt)
);

// File: tb/msync_top_tb_top.sv
`timescale 1ns/1ps
module msync_top_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] async_in;
    logic [W-1:0] inj_en;
    logic [15:0]  seed;
    logic [W-1:0] sync_out;
    logic [W-1:0] delay_evt;
    logic [W-1:0] bleed_evt;

    always #2.5 clk = ~clk;

    msync_top #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (async_in),
        .inj_en    (inj_en),
        .seed      (seed),
        .sync_out  (sync_out),
        .delay_evt (delay_evt),
        .bleed_evt (bleed_evt)
    );

    int          checks = 0;
    int          errors = 0;
    int          age   [W];
    int          lat   [W];
    logic        old_v [W];
    logic        new_v [W];
    int          n_nom = 0;
    int          n_late = 0;
    int          n_early = 0;
    int          mixed_cnt = 0;
    logic [31:0] sig;
    logic [31:0] sig_a;
    bit          rec = 1'b0;
    logic [31:0] lcg;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < W; i++) begin
            age[i]   = 100;
            lat[i]   = 2;
            old_v[i] = 1'b0;
            new_v[i] = 1'b0;
        end
    endtask

    task automatic tick(input logic [W-1:0] want, input logic [W-1:0] inj);
        logic [W-1:0] ready;
        logic [W-1:0] v;
        int           first_lat;
        bit           mixed;
        @(negedge clk);
        first_lat = -1;
        mixed     = 1'b0;
        for (int i = 0; i < W; i++) begin
            logic  expv;
            string req;
            if (age[i] < 100) age[i]++;
            if (age[i] == 1) begin
                chk(!(delay_evt[i] && bleed_evt[i]), "R10 flags exclusive",
                    {delay_evt[i], bleed_evt[i]}, 0);
                if (!inj_en[i])
                    chk(!delay_evt[i] && !bleed_evt[i], "R2 no event with injection off",
                        {delay_evt[i], bleed_evt[i]}, 0);
                lat[i] = bleed_evt[i] ? 1 : (delay_evt[i] ? 3 : 2);
                if (lat[i] == 1) n_early++;
                else if (lat[i] == 3) n_late++;
                else n_nom++;
                if (first_lat < 0) first_lat = lat[i];
                else if (first_lat != lat[i]) mixed = 1'b1;
            end else begin
                req = (age[i] == 2 && lat[i] == 3) ? "R6 no pick after late pick"
                                                   : "R7 no event without transition";
                chk(!delay_evt[i] && !bleed_evt[i], req, {delay_evt[i], bleed_evt[i]}, 0);
            end
            expv = (age[i] >= lat[i]) ? new_v[i] : old_v[i];
            if (age[i] >= 4)       req = "R9 settled output";
            else if (!inj_en[i])   req = "R2 plain latency";
            else if (lat[i] == 1)  req = "R5 early pick latency";
            else if (lat[i] == 3)  req = "R4 late pick latency";
            else                   req = "R3 nominal latency";
            chk(sync_out[i] === expv, req, sync_out[i], expv);
        end
        if (mixed) mixed_cnt++;
        if (rec) sig = {sig[30:0], sig[31]} ^ 32'(delay_evt) ^ (32'(bleed_evt) << 16);
        for (int i = 0; i < W; i++) ready[i] = (age[i] >= 4);
        v = (want & ready) | (async_in & ~ready);
        for (int i = 0; i < W; i++) begin
            if (v[i] !== async_in[i]) begin
                old_v[i] = new_v[i];
                new_v[i] = v[i];
                age[i]   = 0;
            end
        end
        async_in = v;
        inj_en   = inj;
    endtask

    task automatic run_random(input int n, input logic [W-1:0] inj);
        for (int k = 0; k < n; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            tick(async_in ^ W'(lcg >> 16), inj);
        end
    endtask

    task automatic settle(input int n, input logic [W-1:0] inj);
        for (int k = 0; k < n; k++) tick(async_in, inj);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        async_in = '0;
        inj_en   = '0;
        repeat (3) @(negedge clk);
        chk(sync_out === '0, "R1 output clear", sync_out, 0);
        chk(delay_evt === '0, "R1 late flags clear", delay_evt, 0);
        chk(bleed_evt === '0, "R1 early flags clear", bleed_evt, 0);
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        seed     = 16'h1234;
        rst_n    = 1'b0;
        async_in = '0;
        inj_en   = '0;
        model_reset();
        do_reset();

        // Injected run recorded for the R11 replay
        rec = 1'b1; sig = '0; lcg = 32'd7;
        run_random(300, '1);
        rec = 1'b0; sig_a = sig;
        settle(4, '1);

        // R8: whole-bus toggles
        for (int k = 0; k < 40; k++) begin
            tick(~async_in, '1);
            settle(4, '1);
        end

        // R2: injection off
        lcg = 32'd99;
        run_random(60, '0);
        settle(4, '0);

        // Half-enabled mask
        run_random(150, 8'h0F);
        settle(4, 8'h0F);

        // R7: stable input with injection on
        settle(20, '1);
        chk(sync_out === async_in, "R9 final value", sync_out, async_in);

        chk(n_nom > 0, "R3 nominal seen", n_nom, 1);
        chk(n_late > 0, "R4 late pick seen", n_late, 1);
        chk(n_early > 0, "R5 early pick seen", n_early, 1);
        chk(mixed_cnt > 0, "R8 differing latencies on one edge", mixed_cnt, 1);

        // R11: replay with same seed
        do_reset();
        rec = 1'b1; sig = '0; lcg = 32'd7;
        run_random(300, '1);
        rec = 1'b0;
        chk(sig === sig_a, "R11 same seed same events", sig, sig_a);

        finish_run();
    end

endmodule